// File: doc/BRIEF.md
# Palette Host Access Port

This block is the processor-facing register interface of a color lookup palette. A host drives a 3-bit register select, one-cycle read and write strobes and an 8-bit data bus. The bus is split into a write-data input, a read-data output and an output-enable, which the pad ring merges into one bidirectional bus. One 8-bit address register indexes both the 256-entry main palette and the small overlay palette. The select code that loads the address decides two things: which palette is targeted, and whether the access is a load or a read-back.

Colors move over the bus one byte at a time, in the order red, green, blue. On writes the first two bytes are staged. The blue byte commits the full 24-bit word and advances the address. On reads a holding register pre-fetches the entry, the three bytes are returned from it, and the blue read pre-fetches the next entry. Both storage arrays also have a synchronous lookup port for the pixel pipeline, which runs alongside host traffic.

Top module: `pal_host_port`

## Requirements
- R1: After reset the address register reads 0x00, the pixel mask register reads 0xFF, the command register reads 0x00, and the byte sequence starts at red.
- R2: A write with select 000, 011, 100 or 111 loads the address register. A read with any of these four codes returns the address register.
- R3: Data writes with select 001 stage red, then green. The main palette entry at the current address changes only on the third (blue) write, which stores {red, green, blue} with red in bits 23:16.
- R4: After each blue data write the address register increments by one, wrapping from 0xFF to 0x00.
- R5: A write with select 011 copies the main palette entry at the written address into the holding register, and the address becomes that value plus one.
- R6: Data reads with select 001 return red, green, then blue from the holding register. The blue read reloads the holding register from the entry at the current address, and the address increments.
- R7: Selects 100 (load for writing), 111 (load for reading) and 101 (data) apply the same sequence to the overlay palette, whose valid entries are addresses 1 to 15.
- R8: An overlay data write at address 0 or above 15 changes no overlay entry. An overlay read-back from such an address returns 0x00 for each byte.
- R9: Select 010 writes and reads the 8-bit pixel mask register.
- R10: Select 110 writes and reads the 8-bit command register. While command bit 1 is set, data writes store only bits 5:0 of each byte, and data reads return bits 7:6 as zero.
- R11: Any write that loads the address register returns the byte sequence to red.
- R12: The pixel ports return the addressed entry one clock after the index is presented. If the host commits to the same entry in that cycle, the pixel port returns the old contents.
- R13: The output enable is high, and read data may be non-zero, only while a read strobe is present without a write strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| host_sel | input | 3 | Register select code |
| host_wr | input | 1 | Write strobe, one cycle per access |
| host_rd | input | 1 | Read strobe, one cycle per access |
| host_wdata | input | 8 | Host write data |
| host_rdata | output | 8 | Host read data, valid in the strobe cycle |
| host_oe | output | 1 | Drive enable for the shared data bus |
| pix_idx | input | 8 | Main palette pixel lookup index |
| pix_rgb | output | 24 | Main palette lookup result, one cycle later |
| ovl_idx | input | 4 | Overlay palette pixel lookup index |
| ovl_rgb | output | 24 | Overlay lookup result, one cycle later |

## Verification
The palette is loaded with byte triples from several start addresses: a fresh triple, an overwrite of an entry that is already valid, a triple that crosses 0xFF, and a triple that a fresh address load interrupts halfway. Peeking at the pixel port and the address register between bytes separates a commit on the blue byte from a commit on earlier bytes. It also separates a single increment per triple from an increment per byte. Read-backs of two consecutive entries test the pre-fetch and the reload after blue. The overlay is written at addresses inside and outside its valid range, which exposes any missing range gate. A write and a pixel lookup on the same entry in one cycle test the old-data rule, and the narrow mode is checked on both the write path and the read path.

// File: rtl/pal_host_pkg.sv
// Shared types and select codes for the palette host port.
// Assumes 8-bit color components packed red-high into a 24-bit word.
package pal_host_pkg;
    localparam int COMP_W     = 8;
    localparam int WORD_W     = 3 * COMP_W;
    localparam int NARROW_BIT = 1;

    localparam logic [2:0] SEL_LD_PAL_WR = 3'b000;
    localparam logic [2:0] SEL_PAL_DATA  = 3'b001;
    localparam logic [2:0] SEL_MASK      = 3'b010;
    localparam logic [2:0] SEL_LD_PAL_RD = 3'b011;
    localparam logic [2:0] SEL_LD_OVL_WR = 3'b100;
    localparam logic [2:0] SEL_OVL_DATA  = 3'b101;
    localparam logic [2:0] SEL_CMD       = 3'b110;
    localparam logic [2:0] SEL_LD_OVL_RD = 3'b111;

    typedef enum logic [1:0] {
        SEQ_RED   = 2'd0,
        SEQ_GREEN = 2'd1,
        SEQ_BLUE  = 2'd2
    } seq_e;

    typedef struct packed {
        logic [COMP_W-1:0] r;
        logic [COMP_W-1:0] g;
        logic [COMP_W-1:0] b;
    } rgb_t;

    function automatic logic is_addr_load(input logic [2:0] s);
        return (s == SEL_LD_PAL_WR) || (s == SEL_LD_PAL_RD) ||
               (s == SEL_LD_OVL_WR) || (s == SEL_LD_OVL_RD);
    endfunction
endpackage

// File: rtl/pal_store.sv
// Palette storage array: one host write port, one combinational host
// read port and one registered pixel read port.
// Assumes a single clock; a write and a pixel read of the same entry in
// one cycle return the old word. CLEAR_ON_RST selects a variant that
// zeroes every entry on reset (meant for small arrays only).
module pal_store #(
    parameter int DEPTH        = 256,
    parameter int W            = 24,
    parameter bit CLEAR_ON_RST = 1'b0,
    localparam int AW          = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [W-1:0]  wdata,
    input  logic [AW-1:0] haddr,
    output logic [W-1:0]  hq,
    input  logic [AW-1:0] paddr,
    output logic [W-1:0]  pq
);
    logic [W-1:0] mem [DEPTH];

    // Host-side read is combinational for pre-fetch into the holding register.
    assign hq = mem[haddr];

    // Pixel-side registered lookup, sampling the array before this edge's write.
    always_ff @(posedge clk) begin
        if (!rst_n) pq <= '0;
        else        pq <= mem[paddr];
    end

    generate
        if (CLEAR_ON_RST) begin : g_clr
            // Write port with reset clear of every entry.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
                end else if (we) begin
                    mem[waddr] <= wdata;
                end
            end
        end else begin : g_noclr
            // Write port without reset, as a plain RAM.
            always_ff @(posedge clk) begin
                if (we) mem[waddr] <= wdata;
            end
        end
    endgenerate
endmodule

// File: rtl/pal_seq_ctrl.sv
// Host access sequencer: select decode, address register, red/green/blue
// byte sequence, write staging, read holding register, mask and command
// registers. Assumes strobes last one cycle; a write strobe wins over a
// simultaneous read strobe.
module pal_seq_ctrl
    import pal_host_pkg::*;
#(
    parameter int OVL_HI = 15,
    localparam int AW    = COMP_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [2:0]    sel,
    input  logic          wr,
    input  logic          rd,
    input  logic [7:0]    wdata,
    input  rgb_t          pal_q,
    input  rgb_t          ovl_q,
    output logic [AW-1:0] addr_q,
    output logic [AW-1:0] look_addr,
    output seq_e          seq_q,
    output rgb_t          hold_q,
    output rgb_t          wr_word,
    output logic [7:0]    mask_q,
    output logic [7:0]    cmd_q,
    output logic          pal_we,
    output logic          ovl_we
);
    logic [7:0] r_stage, g_stage;
    logic [7:0] byte_in;
    logic       narrow;
    logic       load_wr, data_wr, data_rd;
    logic       look_ovl_ok, cur_ovl_ok;
    rgb_t       ovl_src;
    rgb_t       next_src;
    seq_e       seq_nx;

    function automatic logic ovl_in_range(input logic [AW-1:0] a);
        return (a != '0) && (int'(a) <= OVL_HI);
    endfunction

    // Decode strobes and select into access classes.
    always_comb begin
        load_wr = wr && is_addr_load(sel);
        data_wr = wr && ((sel == SEL_PAL_DATA) || (sel == SEL_OVL_DATA));
        data_rd = rd && !wr && ((sel == SEL_PAL_DATA) || (sel == SEL_OVL_DATA));
    end

    // Narrow mode trims each incoming byte to its low six bits.
    assign narrow  = cmd_q[NARROW_BIT];
    assign byte_in = narrow ? {2'b00, wdata[5:0]} : wdata;

    // Host lookup address: the byte being loaded, else the live address.
    assign look_addr   = load_wr ? wdata : addr_q;
    assign look_ovl_ok = ovl_in_range(look_addr);
    assign cur_ovl_ok  = ovl_in_range(addr_q);
    assign ovl_src     = look_ovl_ok ? ovl_q : '0;

    // Source of a pre-fetch on the blue read, chosen by the data select.
    assign next_src = (sel == SEL_OVL_DATA) ? ovl_src : pal_q;

    // Word committed on the blue write and the two array write enables.
    assign wr_word = '{r: r_stage, g: g_stage, b: byte_in};
    assign pal_we  = data_wr && (sel == SEL_PAL_DATA) && (seq_q == SEQ_BLUE);
    assign ovl_we  = data_wr && (sel == SEL_OVL_DATA) && (seq_q == SEQ_BLUE) && cur_ovl_ok;

    // Next position in the red/green/blue byte sequence.
    always_comb begin
        unique case (seq_q)
            SEQ_RED:   seq_nx = SEQ_GREEN;
            SEQ_GREEN: seq_nx = SEQ_BLUE;
            default:   seq_nx = SEQ_RED;
        endcase
    end

    // Address register, byte sequence, staging and holding registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q  <= '0;
            seq_q   <= SEQ_RED;
            r_stage <= '0;
            g_stage <= '0;
            hold_q  <= '0;
        end else if (load_wr) begin
            seq_q <= SEQ_RED;
            if (sel == SEL_LD_PAL_RD) begin
                hold_q <= pal_q;
                addr_q <= AW'(wdata + 8'd1);
            end else if (sel == SEL_LD_OVL_RD) begin
                hold_q <= ovl_src;
                addr_q <= AW'(wdata + 8'd1);
            end else begin
                addr_q <= wdata;
            end
        end else if (data_wr) begin
            seq_q <= seq_nx;
            if (seq_q == SEQ_RED)   r_stage <= byte_in;
            if (seq_q == SEQ_GREEN) g_stage <= byte_in;
            if (seq_q == SEQ_BLUE)  addr_q  <= AW'(addr_q + 1'b1);
        end else if (data_rd) begin
            seq_q <= seq_nx;
            if (seq_q == SEQ_BLUE) begin
                hold_q <= next_src;
                addr_q <= AW'(addr_q + 1'b1);
            end
        end
    end

    // Pixel mask and command registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask_q <= 8'hFF;
            cmd_q  <= 8'h00;
        end else if (wr) begin
            if (sel == SEL_MASK) mask_q <= wdata;
            if (sel == SEL_CMD)  cmd_q  <= wdata;
        end
    end
endmodule

// File: rtl/pal_host_port.sv
// Palette host access port top: sequencer, main palette, overlay palette
// and the host read-data multiplexer. Assumes the pad ring merges
// host_wdata, host_rdata and host_oe into one bidirectional bus.
module pal_host_port
    import pal_host_pkg::*;
#(
    parameter int OVL_HI = 15,
    localparam int AW    = COMP_W,
    localparam int PAL_N = 1 << AW,
    localparam int OVL_N = 1 << $clog2(OVL_HI + 1),
    localparam int OAW   = $clog2(OVL_N)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [2:0]        host_sel,
    input  logic              host_wr,
    input  logic              host_rd,
    input  logic [7:0]        host_wdata,
    output logic [7:0]        host_rdata,
    output logic              host_oe,
    input  logic [AW-1:0]     pix_idx,
    output logic [WORD_W-1:0] pix_rgb,
    input  logic [OAW-1:0]    ovl_idx,
    output logic [WORD_W-1:0] ovl_rgb
);
    logic [AW-1:0] addr_q, look_addr;
    seq_e          seq_q;
    rgb_t          hold_q, wr_word, pal_q, ovl_q;
    logic [7:0]    mask_q, cmd_q;
    logic          pal_we, ovl_we;
    logic [7:0]    hold_byte;

    pal_seq_ctrl #(.OVL_HI(OVL_HI)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .sel(host_sel), .wr(host_wr), .rd(host_rd),
        .wdata(host_wdata), .pal_q(pal_q), .ovl_q(ovl_q),
        .addr_q(addr_q), .look_addr(look_addr), .seq_q(seq_q),
        .hold_q(hold_q), .wr_word(wr_word), .mask_q(mask_q), .cmd_q(cmd_q),
        .pal_we(pal_we), .ovl_we(ovl_we)
    );

    pal_store #(.DEPTH(PAL_N), .W(WORD_W), .CLEAR_ON_RST(1'b0)) u_pal (
        .clk(clk), .rst_n(rst_n), .we(pal_we), .waddr(addr_q), .wdata(wr_word),
        .haddr(look_addr), .hq(pal_q), .paddr(pix_idx), .pq(pix_rgb)
    );

    pal_store #(.DEPTH(OVL_N), .W(WORD_W), .CLEAR_ON_RST(1'b1)) u_ovl (
        .clk(clk), .rst_n(rst_n), .we(ovl_we), .waddr(addr_q[OAW-1:0]),
        .wdata(wr_word), .haddr(look_addr[OAW-1:0]), .hq(ovl_q),
        .paddr(ovl_idx), .pq(ovl_rgb)
    );

    // Pick the holding byte for the current sequence step, trimmed in narrow mode.
    always_comb begin
        unique case (seq_q)
            SEQ_RED:   hold_byte = hold_q.r;
            SEQ_GREEN: hold_byte = hold_q.g;
            default:   hold_byte = hold_q.b;
        endcase
        if (cmd_q[NARROW_BIT]) hold_byte[7:6] = 2'b00;
    end

    // Host read-data multiplexer; drives only on a read without a write.
    always_comb begin
        host_oe    = host_rd && !host_wr;
        host_rdata = '0;
        if (host_oe) begin
            unique case (host_sel)
                SEL_PAL_DATA, SEL_OVL_DATA: host_rdata = hold_byte;
                SEL_MASK:                   host_rdata = mask_q;
                SEL_CMD:                    host_rdata = cmd_q;
                default:                    host_rdata = addr_q;
            endcase
        end
    end
endmodule

// File: rtl/pal_host_port_chk.sv
// Property checker for the palette host port, bound to the top module.
// Assumes access to the sequencer's address, sequence, mask and overlay
// write enable through the top's internal nets.
module pal_host_port_chk #(
    parameter int OVL_HI = 15
) (
    input logic       clk,
    input logic       rst_n,
    input logic [2:0] host_sel,
    input logic       host_wr,
    input logic       host_rd,
    input logic [7:0] host_rdata,
    input logic       host_oe,
    input logic [7:0] addr_q,
    input logic [1:0] seq_q,
    input logic [7:0] mask_q,
    input logic       ovl_we
);
    logic data_sel, ld_sel;
    assign data_sel = (host_sel == 3'b001) || (host_sel == 3'b101);
    assign ld_sel   = (host_sel == 3'b000) || (host_sel == 3'b011) ||
                      (host_sel == 3'b100) || (host_sel == 3'b111);

    AST_ADDR_STEP_ON_BLUE: assert property (@(posedge clk) disable iff (!rst_n)
        (host_wr && data_sel && seq_q == 2'd2) |=> (addr_q == 8'($past(addr_q) + 8'd1))); // R4
    AST_ADDR_HELD_MID_TRIPLE: assert property (@(posedge clk) disable iff (!rst_n)
        (host_wr && data_sel && seq_q != 2'd2) |=> (addr_q == $past(addr_q))); // R3
    AST_LOAD_RESTARTS_SEQ: assert property (@(posedge clk) disable iff (!rst_n)
        (host_wr && ld_sel) |=> (seq_q == 2'd0)); // R11
    AST_MASK_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
        !(host_wr && host_sel == 3'b010) |=> $stable(mask_q)); // R9
    AST_OVL_WRITE_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        ovl_we |-> (addr_q != 8'd0 && int'(addr_q) <= OVL_HI)); // R8
    AST_BUS_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !(host_rd && !host_wr) |-> (host_rdata == 8'd0 && !host_oe)); // R13
endmodule

bind pal_host_port pal_host_port_chk #(.OVL_HI(OVL_HI)) u_chk (
    .clk(clk), .rst_n(rst_n), .host_sel(host_sel), .host_wr(host_wr),
    .host_rd(host_rd), .host_rdata(host_rdata), .host_oe(host_oe),
    .addr_q(addr_q), .seq_q(seq_q), .mask_q(mask_q), .ovl_we(ovl_we)
);

// File: tb/tb_pal_host_port.sv
// Bench for the palette host port: a vector table of host and pixel
// operations walked by one loop, then directed reset and corner tests.
module tb_pal_host_port;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  host_sel = '0;
    logic        host_wr = 1'b0, host_rd = 1'b0;
    logic [7:0]  host_wdata = '0;
    logic [7:0]  host_rdata;
    logic        host_oe;
    logic [7:0]  pix_idx = '0;
    logic [23:0] pix_rgb;
    logic [3:0]  ovl_idx = '0;
    logic [23:0] ovl_rgb;

    int n_chk = 0, n_bad = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    pal_host_port dut (
        .clk(clk), .rst_n(rst_n), .host_sel(host_sel), .host_wr(host_wr),
        .host_rd(host_rd), .host_wdata(host_wdata), .host_rdata(host_rdata),
        .host_oe(host_oe), .pix_idx(pix_idx), .pix_rgb(pix_rgb),
        .ovl_idx(ovl_idx), .ovl_rgb(ovl_rgb)
    );

    // kind: 0 host write, 1 host read, 2 main pixel lookup, 3 overlay lookup
    localparam int NV = 83;
    localparam logic [44:0] VEC [NV] = '{
        {2'd0,3'd0,8'h10,24'h0,8'd2},      // R2 load address, write mode
        {2'd0,3'd1,8'h11,24'h0,8'd3},
        {2'd0,3'd1,8'h22,24'h0,8'd3},
        {2'd1,3'd0,8'h00,24'h10,8'd3},     // R3 address held mid-triple
        {2'd0,3'd1,8'h33,24'h0,8'd3},
        {2'd1,3'd0,8'h00,24'h11,8'd4},     // R4 one increment per triple
        {2'd2,3'd0,8'h10,24'h112233,8'd3}, // R3 red in high byte
        {2'd0,3'd1,8'h44,24'h0,8'd4},
        {2'd0,3'd1,8'h55,24'h0,8'd4},
        {2'd0,3'd1,8'h66,24'h0,8'd4},
        {2'd1,3'd0,8'h00,24'h12,8'd4},     // R4
        {2'd0,3'd0,8'h10,24'h0,8'd3},
        {2'd0,3'd1,8'hA1,24'h0,8'd3},
        {2'd0,3'd1,8'hA2,24'h0,8'd3},
        {2'd2,3'd0,8'h10,24'h112233,8'd3}, // R3 old word until blue
        {2'd0,3'd1,8'hA3,24'h0,8'd3},
        {2'd2,3'd0,8'h10,24'hA1A2A3,8'd3}, // R3 committed on blue
        {2'd0,3'd0,8'hFF,24'h0,8'd4},
        {2'd0,3'd1,8'h01,24'h0,8'd4},
        {2'd0,3'd1,8'h02,24'h0,8'd4},
        {2'd0,3'd1,8'h03,24'h0,8'd4},
        {2'd1,3'd0,8'h00,24'h00,8'd4},     // R4 wrap FF -> 00
        {2'd2,3'd0,8'hFF,24'h010203,8'd4}, // R4
        {2'd0,3'd0,8'h20,24'h0,8'd11},
        {2'd0,3'd1,8'h77,24'h0,8'd11},
        {2'd0,3'd0,8'h20,24'h0,8'd11},     // R11 reload mid-triple
        {2'd0,3'd1,8'h0A,24'h0,8'd11},
        {2'd0,3'd1,8'h0B,24'h0,8'd11},
        {2'd0,3'd1,8'h0C,24'h0,8'd11},
        {2'd2,3'd0,8'h20,24'h0A0B0C,8'd11},// R11 sequence restarted at red
        {2'd0,3'd3,8'h10,24'h0,8'd5},      // R5 load in read mode
        {2'd1,3'd0,8'h00,24'h11,8'd5},     // R5 address = loaded + 1
        {2'd1,3'd1,8'h00,24'hA1,8'd6},     // R6
        {2'd1,3'd1,8'h00,24'hA2,8'd6},
        {2'd1,3'd1,8'h00,24'hA3,8'd6},
        {2'd1,3'd0,8'h00,24'h12,8'd6},     // R6 increment after blue read
        {2'd1,3'd1,8'h00,24'h44,8'd6},     // R6 next entry pre-fetched
        {2'd1,3'd1,8'h00,24'h55,8'd6},
        {2'd1,3'd1,8'h00,24'h66,8'd6},
        {2'd0,3'd2,8'h5A,24'h0,8'd9},
        {2'd1,3'd2,8'h00,24'h5A,8'd9},     // R9 mask read-back
        {2'd0,3'd4,8'h03,24'h0,8'd7},
        {2'd0,3'd5,8'hC1,24'h0,8'd7},
        {2'd0,3'd5,8'hC2,24'h0,8'd7},
        {2'd0,3'd5,8'hC3,24'h0,8'd7},
        {2'd1,3'd4,8'h00,24'h04,8'd7},     // R7 overlay increment
        {2'd3,3'd0,8'h03,24'hC1C2C3,8'd7}, // R7 overlay commit
        {2'd0,3'd7,8'h03,24'h0,8'd7},
        {2'd1,3'd5,8'h00,24'hC1,8'd7},     // R7 overlay read-back
        {2'd1,3'd5,8'h00,24'hC2,8'd7},
        {2'd1,3'd5,8'h00,24'hC3,8'd7},
        {2'd0,3'd4,8'h00,24'h0,8'd8},
        {2'd0,3'd5,8'hD1,24'h0,8'd8},
        {2'd0,3'd5,8'hD2,24'h0,8'd8},
        {2'd0,3'd5,8'hD3,24'h0,8'd8},      // R8 write at 0 dropped
        {2'd0,3'd4,8'h10,24'h0,8'd8},
        {2'd0,3'd5,8'hE1,24'h0,8'd8},
        {2'd0,3'd5,8'hE2,24'h0,8'd8},
        {2'd0,3'd5,8'hE3,24'h0,8'd8},      // R8 write at 16 dropped
        {2'd3,3'd0,8'h00,24'h000000,8'd8}, // R8 entry 0 untouched
        {2'd0,3'd7,8'h00,24'h0,8'd8},
        {2'd1,3'd5,8'h00,24'h00,8'd8},     // R8 read-back zero
        {2'd1,3'd5,8'h00,24'h00,8'd8},
        {2'd1,3'd5,8'h00,24'h00,8'd8},
        {2'd0,3'd6,8'h02,24'h0,8'd10},
        {2'd1,3'd6,8'h00,24'h02,8'd10},    // R10 command read-back
        {2'd0,3'd0,8'h30,24'h0,8'd10},
        {2'd0,3'd1,8'hFF,24'h0,8'd10},
        {2'd0,3'd1,8'hFE,24'h0,8'd10},
        {2'd0,3'd1,8'hC5,24'h0,8'd10},
        {2'd2,3'd0,8'h30,24'h3F3E05,8'd10},// R10 narrow store
        {2'd0,3'd3,8'h11,24'h0,8'd10},
        {2'd1,3'd1,8'h00,24'h04,8'd10},    // R10 narrow read of 0x44
        {2'd1,3'd1,8'h00,24'h15,8'd10},
        {2'd1,3'd1,8'h00,24'h26,8'd10},
        {2'd0,3'd6,8'h00,24'h0,8'd10},
        {2'd0,3'd0,8'h40,24'h0,8'd12},
        {2'd0,3'd1,8'h99,24'h0,8'd12},
        {2'd0,3'd1,8'h99,24'h0,8'd12},
        {2'd0,3'd1,8'h99,24'h0,8'd12},
        {2'd0,3'd0,8'h40,24'h0,8'd12},
        {2'd0,3'd1,8'h01,24'h0,8'd12},
        {2'd0,3'd1,8'h02,24'h0,8'd12}
    };

    task automatic check(input int req, input logic [23:0] act, input logic [23:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL R%0d: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    endtask

    // Called at a negedge; leaves the bench at a later negedge.
    task automatic host_read(input logic [2:0] s, input logic [7:0] exp, input int req);
        host_sel = s; host_rd = 1'b1;
        #2 check(req, {16'h0, host_rdata}, {16'h0, exp});
        @(negedge clk); host_rd = 1'b0;
    endtask

    task automatic host_write(input logic [2:0] s, input logic [7:0] d);
        host_sel = s; host_wdata = d; host_wr = 1'b1;
        @(negedge clk); host_wr = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        host_read(3'd0, 8'h00, 1);
        host_read(3'd2, 8'hFF, 1);
        host_read(3'd6, 8'h00, 1);
        for (int i = 0; i < NV; i++) begin
            logic [1:0]  k;
            logic [2:0]  s;
            logic [7:0]  d;
            logic [23:0] e;
            int          r;
            k = VEC[i][44:43]; s = VEC[i][42:40]; d = VEC[i][39:32];
            e = VEC[i][31:8];  r = int'(VEC[i][7:0]);
            case (k)
                2'd0: host_write(s, d);
                2'd1: host_read(s, e[7:0], r);
                2'd2: begin pix_idx = d; @(negedge clk); check(r, pix_rgb, e); end
                default: begin ovl_idx = d[3:0]; @(negedge clk); check(r, ovl_rgb, e); end
            endcase
        end
        // R12 host commit and pixel lookup of entry 0x40 in the same cycle
        pix_idx = 8'h40;
        host_write(3'd1, 8'h03);
        check(12, pix_rgb, 24'h999999);
        @(negedge clk);
        check(12, pix_rgb, 24'h010203);
        // R13 bus idle without a read strobe, driven with one
        #2 check(13, {22'h0, host_oe, |host_rdata}, 24'h0);
        host_sel = 3'd2; host_rd = 1'b1;
        #2 check(13, {23'h0, host_oe}, 24'h1);
        @(negedge clk); host_rd = 1'b0;
        // R13 write strobe alongside a read keeps the bus off
        host_sel = 3'd2; host_wdata = 8'h77; host_wr = 1'b1; host_rd = 1'b1;
        #2 check(13, {23'h0, host_oe}, 24'h0);
        @(negedge clk); host_wr = 1'b0; host_rd = 1'b0;
        host_read(3'd2, 8'h77, 9);  // R9
        // R1 reset in mid-run returns registers to their reset values
        host_write(3'd0, 8'h55);
        host_write(3'd6, 8'h02);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        host_read(3'd0, 8'h00, 1);
        host_read(3'd6, 8'h00, 1);
        host_read(3'd2, 8'hFF, 1);
        finish_run();
    end

    // Watchdog: an expired run is a failed check.
    initial begin
        repeat (20000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end
endmodule